// File: doc/BRIEF.md
# Start-Up Option Load Sequencer

This block governs how a small controller leaves reset. While the external active-low reset pin is low, every output that could start the core stays inactive and all option registers hold zero. Once the pin goes high (after a short synchronizer), the sequencer waits a programmable number of oscillator clocks so the oscillator can settle. It then opens a loading window of a fixed number of clocks (512 by default, about 128 µs at 4 MHz). During this window it reads a run of configuration words from a reserved region of program memory into its option registers.

Reads use a plain synchronous port. A request with an address in one cycle returns data in the next. One word is fetched per clock from consecutive addresses at the start of the window, and the rest of the window is idle padding. When the window closes, the core is released. In the first cycle of execution a one-cycle strobe tells the program counter to load the start vector, which is zero. Pulling the pin low again at any time drops the block back to its held state and clears the options.

Top module: `rst_option_seq`

## Requirements
- R1: While the synchronized reset is active (two clock edges after the pin goes low), `cpu_run`, `pc_load` and `opt_rd_en` are 0 and `opt_words` is all zeros.
- R2: After the pin is released, no option read is issued during the settle period of SETTLE clocks.
- R3: The first read request appears SETTLE+2 edges after the first edge that samples the pin high. Exactly WORDS requests follow on consecutive clocks, at addresses OPT_BASE, OPT_BASE+1, and so on upward.
- R4: The word returned for the read at OPT_BASE+i (one cycle after its request) is stored in field i of `opt_words`, bits [i*W +: W], with field 0 in the least significant bits.
- R5: `cpu_run` rises exactly SETTLE+WINDOW+2 edges after the first edge that samples the pin high, so the loading window lasts WINDOW clocks including its idle padding.
- R6: `pc_load` is high for exactly one cycle, the first cycle in which `cpu_run` is high, and `pc_start` equals zero.
- R7: Once high, `cpu_run` stays high and `opt_words` stays unchanged until the reset pin is asserted again.
- R8: Asserting the pin during settling, during the reads, during the padding, or during execution returns the block to the R1 state within three edges. A later release repeats the whole sequence.
- R9: No read request is issued after the first WORDS cycles of the window or while `cpu_run` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous to clk |
| opt_rd_en | output | 1 | Option memory read request |
| opt_rd_addr | output | ADDR_W | Option memory read address |
| opt_rd_data | input | W | Read data, valid the cycle after the request |
| opt_words | output | WORDS*W | Loaded option registers, field i at bits [i*W +: W] |
| cpu_run | output | 1 | Core run enable |
| pc_load | output | 1 | One-cycle strobe to load the program counter |
| pc_start | output | PC_W | Start vector for the program counter (zero) |

## Verification
The assertions assume the option memory answers each request exactly one cycle later and that reset pin changes are held long enough for the synchronizer to register them. The bench's memory model is a single register clocked on the request, so it always returns data with that one-cycle latency. The bench changes the pin only on falling clock edges and keeps it low for at least four cycles before each release. It also changes the memory pattern only while the block is held.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Start-up phases of the sequencer, in the order they are visited.
    typedef enum logic [1:0] {
        PH_HOLD   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_FETCH  = 2'd2,
        PH_RUN    = 2'd3
    } phase_e;

    // Larger of two counts, used to size the shared phase counter.
    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Index width that stays legal for a single-entry bank.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic hold
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) sr <= pin_n;
        end else begin : g_many
            always_ff @(posedge clk) sr <= {sr[STAGES-2:0], pin_n};
        end
    endgenerate

    // Active-high synchronous reset for the rest of the block.
    assign hold = ~sr[STAGES-1];
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int unsigned SETTLE   = 16384,
    parameter int unsigned WINDOW   = 512,
    parameter int unsigned WORDS    = 4,
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned OPT_BASE = 'h7F8,
    parameter int unsigned IDXW     = idx_bits(WORDS)
) (
    input  logic              clk,
    input  logic              hold,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cap_en,
    output logic [IDXW-1:0]   cap_idx,
    output logic              run,
    output logic              pc_load
);
    localparam int unsigned CW = $clog2(max_of(SETTLE, WINDOW) + 1);

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic          launched;

    always_ff @(posedge clk) begin
        if (hold) begin
            phase    <= PH_HOLD;
            cnt      <= '0;
            launched <= 1'b0;
        end else begin
            unique case (phase)
                PH_HOLD: begin
                    phase <= PH_SETTLE;
                    cnt   <= '0;
                end
                PH_SETTLE: begin
                    if (cnt == CW'(SETTLE - 1)) begin
                        phase <= PH_FETCH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_FETCH: begin
                    if (cnt == CW'(WINDOW - 1)) begin
                        phase <= PH_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RUN: launched <= 1'b1;
                default: phase <= PH_HOLD;
            endcase
        end
    end

    // Reads occupy the head of the window; the rest is padding.
    assign rd_en   = (phase == PH_FETCH) && (cnt < CW'(WORDS));
    assign rd_addr = ADDR_W'(OPT_BASE) + ADDR_W'(cnt);
    assign run     = (phase == PH_RUN);
    assign pc_load = run && !launched;

    // Capture lags the request by the memory's one-cycle latency.
    always_ff @(posedge clk) begin
        if (hold) begin
            cap_en  <= 1'b0;
            cap_idx <= '0;
        end else begin
            cap_en  <= rd_en;
            cap_idx <= cnt[IDXW-1:0];
        end
    end
endmodule

// File: rtl/rstseq_optbank.sv
module rstseq_optbank #(
    parameter int unsigned WORDS = 4,
    parameter int unsigned W     = 8,
    parameter int unsigned IDXW  = 2
) (
    input  logic               clk,
    input  logic               hold,
    input  logic               cap_en,
    input  logic [IDXW-1:0]    cap_idx,
    input  logic [W-1:0]       rd_data,
    output logic [WORDS*W-1:0] words
);
    generate
        for (genvar g = 0; g < WORDS; g++) begin : g_word
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (hold)
                    q <= '0;
                else if (cap_en && (cap_idx == IDXW'(g)))
                    q <= rd_data;
            end
            assign words[g*W +: W] = q;
        end
    endgenerate
endmodule

// File: rtl/rst_option_seq.sv
module rst_option_seq
    import rstseq_pkg::*;
#(
    parameter int unsigned SETTLE    = 16384,
    parameter int unsigned WINDOW    = 512,
    parameter int unsigned WORDS     = 4,
    parameter int unsigned W         = 8,
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned OPT_BASE  = 'h7F8,
    parameter int unsigned PC_W      = 11,
    parameter int unsigned SYNC_STG  = 2
) (
    input  logic               clk,
    input  logic               rst_pin_n,
    output logic               opt_rd_en,
    output logic [ADDR_W-1:0]  opt_rd_addr,
    input  logic [W-1:0]       opt_rd_data,
    output logic [WORDS*W-1:0] opt_words,
    output logic               cpu_run,
    output logic               pc_load,
    output logic [PC_W-1:0]    pc_start
);
    localparam int unsigned IDXW = idx_bits(WORDS);

    logic            hold;
    logic            cap_en;
    logic [IDXW-1:0] cap_idx;

    rstseq_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .pin_n (rst_pin_n),
        .hold  (hold)
    );

    rstseq_fsm #(
        .SETTLE   (SETTLE),
        .WINDOW   (WINDOW),
        .WORDS    (WORDS),
        .ADDR_W   (ADDR_W),
        .OPT_BASE (OPT_BASE),
        .IDXW     (IDXW)
    ) u_fsm (
        .clk     (clk),
        .hold    (hold),
        .rd_en   (opt_rd_en),
        .rd_addr (opt_rd_addr),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .run     (cpu_run),
        .pc_load (pc_load)
    );

    rstseq_optbank #(
        .WORDS (WORDS),
        .W     (W),
        .IDXW  (IDXW)
    ) u_bank (
        .clk     (clk),
        .hold    (hold),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .rd_data (opt_rd_data),
        .words   (opt_words)
    );

    assign pc_start = '0;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int unsigned OW = 32,
    parameter int unsigned AW = 11
) (
    input logic          clk,
    input logic          hold,
    input logic          cpu_run,
    input logic          pc_load,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic [OW-1:0] words
);
    // R1
    held_quiet_chk: assert property (@(posedge clk)
        hold |=> (!cpu_run && !pc_load && !rd_en && (words == '0)));

    // R6
    pc_strobe_first_chk: assert property (@(posedge clk) disable iff (hold)
        pc_load |-> (cpu_run && !$past(cpu_run)));

    // R7
    run_sticky_chk: assert property (@(posedge clk) disable iff (hold)
        cpu_run |=> (cpu_run && $stable(words)));

    // R9
    no_read_in_run_chk: assert property (@(posedge clk) disable iff (hold)
        rd_en |-> !cpu_run);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (hold)
        (rd_en && $past(rd_en)) |-> (rd_addr == AW'($past(rd_addr) + 1'b1)));
endmodule

bind rst_option_seq rstseq_chk #(.OW(WORDS*W), .AW(ADDR_W)) u_chk (
    .clk     (clk),
    .hold    (hold),
    .cpu_run (cpu_run),
    .pc_load (pc_load),
    .rd_en   (opt_rd_en),
    .rd_addr (opt_rd_addr),
    .words   (opt_words)
);

// File: tb/rst_option_seq_tb.sv
module rst_option_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int S     = 40;
    localparam int WIN   = 512;
    localparam int N     = 4;
    localparam int W     = 8;
    localparam int AW    = 11;
    localparam int BASE  = 'h7F8;
    localparam int PCW   = 11;
    localparam int T_RD  = 2 + S;
    localparam int T_RUN = 2 + S + WIN;

    typedef struct packed {
        logic [31:0] abort_at;
        logic [7:0]  seed;
    } row_t;

    // abort_at = 0: run to completion; otherwise pull reset after that edge
    localparam row_t ROWS [0:5] = '{
        '{32'd0,          8'h5A},
        '{32'd10,         8'h13},
        '{32'(T_RD + 1),  8'hC4},
        '{32'(T_RD + 100),8'h77},
        '{32'(T_RUN + 5), 8'h2E},
        '{32'd0,          8'h91}
    };

    logic               clk = 1'b0;
    logic               rst_pin_n = 1'b0;
    logic               opt_rd_en;
    logic [AW-1:0]      opt_rd_addr;
    logic [W-1:0]       opt_rd_data;
    logic [N*W-1:0]     opt_words;
    logic               cpu_run;
    logic               pc_load;
    logic [PCW-1:0]     pc_start;
    logic [7:0]         seed = 8'h00;
    int                 n_chk = 0;
    int                 n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_option_seq #(
        .SETTLE(S), .WINDOW(WIN), .WORDS(N), .W(W),
        .ADDR_W(AW), .OPT_BASE(BASE), .PC_W(PCW)
    ) u_dut (
        .clk(clk), .rst_pin_n(rst_pin_n),
        .opt_rd_en(opt_rd_en), .opt_rd_addr(opt_rd_addr),
        .opt_rd_data(opt_rd_data), .opt_words(opt_words),
        .cpu_run(cpu_run), .pc_load(pc_load), .pc_start(pc_start)
    );

    function automatic logic [7:0] mem_f(input logic [AW-1:0] a, input logic [7:0] s);
        return (a[7:0] * 8'd29 + s) ^ {5'b0, a[10:8]};
    endfunction

    // Option memory: one-cycle synchronous read
    always @(posedge clk) if (opt_rd_en) opt_rd_data <= mem_f(opt_rd_addr, seed);

    task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_held(input string req);
        check(req, !cpu_run && !pc_load && !opt_rd_en, {cpu_run, pc_load, opt_rd_en}, 64'd0);
        check(req, opt_words == '0, opt_words, 64'd0);
    endtask

    task automatic run_row(input row_t r);
        rst_pin_n = 1'b0;
        repeat (4) @(negedge clk);
        seed = r.seed;
        rst_pin_n = 1'b1;
        for (int n = 0; n <= T_RUN + 3; n++) begin
            logic rd_e, run_e, pc_e;
            @(negedge clk);
            rd_e  = (n >= T_RD) && (n < T_RD + N);
            run_e = (n >= T_RUN);
            pc_e  = (n == T_RUN);
            // R2 R3 R9: read request timing by phase
            check((n < T_RD) ? "R2" : (rd_e ? "R3" : "R9"),
                  opt_rd_en == rd_e, opt_rd_en, rd_e);
            if (rd_e && opt_rd_en)
                check("R3", opt_rd_addr == AW'(BASE + n - T_RD), opt_rd_addr, AW'(BASE + n - T_RD));
            check("R5", cpu_run == run_e, cpu_run, run_e);
            check("R6", pc_load == pc_e, pc_load, pc_e);
            if (r.abort_at != 0 && n == int'(r.abort_at)) begin
                rst_pin_n = 1'b0;
                repeat (3) @(negedge clk);
                check_held("R8");
                return;
            end
        end
        for (int i = 0; i < N; i++)
            check("R4", opt_words[i*W +: W] == mem_f(AW'(BASE + i), r.seed),
                  opt_words[i*W +: W], mem_f(AW'(BASE + i), r.seed));
        check("R6", pc_start == '0, pc_start, 64'd0);
        begin
            logic [N*W-1:0] snap;
            snap = opt_words;
            repeat (25) @(negedge clk);
            check("R7", cpu_run && !pc_load && opt_words == snap, {cpu_run, pc_load}, 64'd2);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state with pin held low
        repeat (6) @(negedge clk);
        check_held("R1");
        seed = 8'hFF;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            check("R1", !opt_rd_en && !cpu_run, {opt_rd_en, cpu_run}, 64'd0);
        end
        // Vector table: full sequences and aborts in each phase (R8)
        foreach (ROWS[i]) run_row(ROWS[i]);
        // Directed: reset during run after a full load clears options (R8)
        rst_pin_n = 1'b0;
        @(negedge clk);
        check("R8", cpu_run, cpu_run, 64'd1);
        repeat (2) @(negedge clk);
        check_held("R8");
        // Directed: full sequence again after that (R8, R4)
        run_row('{32'd0, 8'h3C});
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule